// File: doc/BRIEF.md
# Stacked Mode Register Window

This block gives a host indirect access to three mode registers of one serial channel (called MR0, MR1 and MR2 here) through a single bus location. An internal pointer decides which of the three registers a host read or write reaches. The pointer is placed by reset and by two command strobes from a command decoder. It also steps forward by itself after every accepted access. The three register values are driven out continuously, so downstream logic can use the fields directly.

Host accesses use a valid/ready handshake. An access is accepted in a cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` is low only in a cycle where a pointer command is present. A host that sees `acc_ready` low must keep its request, and it is taken in a later cycle. Read data comes back one cycle after acceptance as a one-cycle `rd_valid` pulse with `rd_data`. There is no back-pressure on the read return path. The `CHAN` parameter selects the first channel (0) or the second channel (1). On the second channel the low nibble of MR0 is unused.

Top module: `moderegs_window`

## Requirements
- R1: After reset all three registers read 0, `rd_valid` is 0, `acc_ready` is 1, and the pointer selects MR1.
- R2: A cycle with `cmd_sel_mr0` high and `cmd_sel_mr1` low sets the pointer to MR0 for the next access.
- R3: A cycle with `cmd_sel_mr1` high sets the pointer to MR1. This also holds when `cmd_sel_mr0` is high in the same cycle, because the MR1 command has priority.
- R4: An accepted read or write while the pointer selects MR1 moves the pointer to MR2.
- R5: An accepted read or write while the pointer selects MR0 moves the pointer to MR1.
- R6: Accepted accesses while the pointer selects MR2 leave it at MR2.
- R7: An accepted read returns, one cycle later, `rd_valid` high for one cycle, with `rd_data` holding the register the pointer selected before it stepped.
- R8: MR0 bit 3 is reserved. It always holds 0, whatever value is written.
- R9: With `CHAN`=1, MR0 bits 3:0 always hold 0. Bits 7:4 are written normally.
- R10: MR0 bits 2:0 are a rate code, and only codes 0 to 5 are legal. A write carrying code 6 or 7 keeps the previous code in bits 2:0 while still updating bits 7:4.
- R11: In a cycle with either command high, `acc_ready` is 0. No register changes, the access does not step the pointer, and no read data is returned for it.
- R12: Writes to MR1 and MR2 store all 8 bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_sel_mr0 | input | 1 | Command strobe: point at MR0 |
| cmd_sel_mr1 | input | 1 | Command strobe: point at MR1 (priority) |
| acc_valid | input | 1 | Host access request |
| acc_ready | output | 1 | Access can be taken this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid (one-cycle pulse) |
| rd_data | output | 8 | Read data |
| mr0_q | output | 8 | MR0 value |
| mr1_q | output | 8 | MR1 value |
| mr2_q | output | 8 | MR2 value |

## Verification
Runs of back-to-back writes starting from reset show where the pointer lands after each step, because each write leaves a distinct byte in exactly one register. Runs of reads after a command separate the value read before a step from the value read after it. Writes with rate codes 6 and 7 and with bit 3 set, repeated on both channel settings, separate the masking rules from plain storage. Commands raised alone, together, and in the same cycle as an access show command priority and the stall of the colliding access.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
  localparam int NUM_MR = 3;

  typedef enum logic [1:0] {
    SEL_MR0 = 2'd0,
    SEL_MR1 = 2'd1,
    SEL_MR2 = 2'd2
  } mr_sel_e;
endpackage

// File: rtl/mrw_pointer.sv
module mrw_pointer
  import mrw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_sel_mr0,
  input  logic    cmd_sel_mr1,
  input  logic    acc_fire,
  output mr_sel_e sel_q
);
  mr_sel_e sel_d;

  always_comb begin
    sel_d = sel_q;
    if (cmd_sel_mr1) begin
      sel_d = SEL_MR1;
    end else if (cmd_sel_mr0) begin
      sel_d = SEL_MR0;
    end else if (acc_fire) begin
      unique case (sel_q)
        SEL_MR0: sel_d = SEL_MR1;
        SEL_MR1: sel_d = SEL_MR2;
        default: sel_d = SEL_MR2;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= SEL_MR1;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/mrw_regfile.sv
module mrw_regfile
  import mrw_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CHAN     = 0,
  parameter int RATE_W   = 3,
  parameter int NUM_RATE = 6,
  parameter int RSVD_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  mr_sel_e       sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] regs_q [NUM_MR]
);
  localparam int NIB_W = 4;

  function automatic logic [DW-1:0] mr0_filter(input logic [DW-1:0] prev,
                                                input logic [DW-1:0] nv);
    logic [DW-1:0] r;
    r = nv;
    if (int'(nv[RATE_W-1:0]) >= NUM_RATE) r[RATE_W-1:0] = prev[RATE_W-1:0];
    r[RSVD_BIT] = 1'b0;
    if (CHAN == 1) r[NIB_W-1:0] = '0;
    return r;
  endfunction

  for (genvar i = 0; i < NUM_MR; i++) begin : g_mr
    logic hit;
    assign hit = wr_fire && (int'(sel) == i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (hit) begin
        if (i == 0) regs_q[i] <= mr0_filter(regs_q[i], wdata);
        else        regs_q[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/mrw_readback.sv
module mrw_readback
  import mrw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  mr_sel_e       sel,
  input  logic [DW-1:0] regs_q [NUM_MR],
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mux_out;

  always_comb begin
    unique case (sel)
      SEL_MR0: mux_out = regs_q[0];
      SEL_MR1: mux_out = regs_q[1];
      default: mux_out = regs_q[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= mux_out;
    end
  end
endmodule

// File: rtl/moderegs_window.sv
module moderegs_window
  import mrw_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CHAN     = 0,
  parameter int RATE_W   = 3,
  parameter int NUM_RATE = 6,
  parameter int RSVD_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_sel_mr0,
  input  logic          cmd_sel_mr1,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic          acc_write,
  input  logic [DW-1:0] acc_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] mr0_q,
  output logic [DW-1:0] mr1_q,
  output logic [DW-1:0] mr2_q
);
  mr_sel_e       sel_cur;
  logic          acc_fire;
  logic [DW-1:0] regs_q [NUM_MR];

  assign acc_ready = !(cmd_sel_mr0 || cmd_sel_mr1);
  assign acc_fire  = acc_valid && acc_ready;

  mrw_pointer u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_sel_mr0 (cmd_sel_mr0),
    .cmd_sel_mr1 (cmd_sel_mr1),
    .acc_fire    (acc_fire),
    .sel_q       (sel_cur)
  );

  mrw_regfile #(
    .DW(DW), .CHAN(CHAN), .RATE_W(RATE_W),
    .NUM_RATE(NUM_RATE), .RSVD_BIT(RSVD_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (acc_fire && acc_write),
    .sel     (sel_cur),
    .wdata   (acc_wdata),
    .regs_q  (regs_q)
  );

  mrw_readback #(.DW(DW)) u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (acc_fire && !acc_write),
    .sel      (sel_cur),
    .regs_q   (regs_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign mr0_q = regs_q[0];
  assign mr1_q = regs_q[1];
  assign mr2_q = regs_q[2];
endmodule

// File: rtl/mrw_checker.sv
module mrw_checker
  import mrw_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CHAN = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_sel_mr0,
  input logic          cmd_sel_mr1,
  input logic          acc_valid,
  input logic          acc_write,
  input mr_sel_e       sel_cur,
  input logic          rd_valid,
  input logic [DW-1:0] mr0_q,
  input logic [DW-1:0] mr1_q,
  input logic [DW-1:0] mr2_q
);
  logic cmd_any, take;
  assign cmd_any = cmd_sel_mr0 || cmd_sel_mr1;
  assign take    = acc_valid && !cmd_any;

  a_r2_cmd_mr0: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sel_mr0 && !cmd_sel_mr1) |=> sel_cur == SEL_MR0);
  a_r3_cmd_mr1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sel_mr1 |=> sel_cur == SEL_MR1);
  a_r4_mr1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel_cur == SEL_MR1) |=> sel_cur == SEL_MR2);
  a_r5_mr0_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel_cur == SEL_MR0) |=> sel_cur == SEL_MR1);
  a_r6_mr2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_any && sel_cur == SEL_MR2) |=> sel_cur == SEL_MR2);
  a_r7_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !acc_write) |=> rd_valid);
  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mr0_q[3] == 1'b0);
  a_r9_chanb_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (CHAN == 1) |-> mr0_q[3:0] == 4'h0);
  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_any |=> ($stable(mr0_q) && $stable(mr1_q) && $stable(mr2_q) && !rd_valid));
endmodule

bind moderegs_window mrw_checker #(.DW(DW), .CHAN(CHAN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_sel_mr0 (cmd_sel_mr0),
  .cmd_sel_mr1 (cmd_sel_mr1),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .sel_cur     (sel_cur),
  .rd_valid    (rd_valid),
  .mr0_q       (mr0_q),
  .mr1_q       (mr1_q),
  .mr2_q       (mr2_q)
);

// File: tb/moderegs_window_bench.sv
`timescale 1ns/1ps
module moderegs_window_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd0 = 1'b0, cmd1 = 1'b0;
  logic       av = 1'b0, aw = 1'b0;
  logic [7:0] wd = 8'h00;
  logic       ardy, rv, ardy_b, rv_b;
  logic [7:0] rd, m0, m1, m2, rd_b, m0_b, m1_b, m2_b;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  moderegs_window u_moderegs_window (
    .clk(clk), .rst_n(rst_n), .cmd_sel_mr0(cmd0), .cmd_sel_mr1(cmd1),
    .acc_valid(av), .acc_ready(ardy), .acc_write(aw), .acc_wdata(wd),
    .rd_valid(rv), .rd_data(rd), .mr0_q(m0), .mr1_q(m1), .mr2_q(m2));

  moderegs_window #(.CHAN(1)) u_moderegs_window_b (
    .clk(clk), .rst_n(rst_n), .cmd_sel_mr0(cmd0), .cmd_sel_mr1(cmd1),
    .acc_valid(av), .acc_ready(ardy_b), .acc_write(aw), .acc_wdata(wd),
    .rd_valid(rv_b), .rd_data(rd_b), .mr0_q(m0_b), .mr1_q(m1_b), .mr2_q(m2_b));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] d);
    @(negedge clk); av = 1'b1; aw = wr; wd = d;
    @(posedge clk); #1; av = 1'b0; aw = 1'b0;
  endtask

  task automatic command(input logic c0, input logic c1);
    @(negedge clk); cmd0 = c0; cmd1 = c1;
    @(posedge clk); #1; cmd0 = 1'b0; cmd1 = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 mr0", m0, 8'h00); check("R1 mr1", m1, 8'h00);
    check("R1 mr2", m2, 8'h00); check("R1 rd_valid", {7'd0, rv}, 8'h00);
    check("R1 ready", {7'd0, ardy}, 8'h01);
    access(1'b1, 8'hA5);
    check("R1 R12 first write lands in mr1", m1, 8'hA5);
    check("R1 mr0 untouched", m0, 8'h00);
  endtask

  task automatic t_steps;
    access(1'b1, 8'h3C);
    check("R4 mr1 steps to mr2", m2, 8'h3C);
    check("R12 mr1 kept", m1, 8'hA5);
    access(1'b1, 8'h77);
    check("R6 mr2 holds", m2, 8'h77);
    check("R6 mr1 unchanged", m1, 8'hA5);
  endtask

  task automatic t_mr0;
    command(1'b1, 1'b0);
    access(1'b1, 8'h2C);
    check("R2 R8 mr0 write, bit3 cleared", m0, 8'h24);
    access(1'b1, 8'h11);
    check("R5 mr0 steps to mr1", m1, 8'h11);
    check("R5 mr0 unchanged", m0, 8'h24);
  endtask

  task automatic t_reads;
    command(1'b1, 1'b0);
    access(1'b0, 8'h00);
    check("R7 rd_valid", {7'd0, rv}, 8'h01);
    check("R7 read mr0", rd, 8'h24);
    access(1'b0, 8'h00);
    check("R7 R5 read mr1", rd, 8'h11);
    access(1'b0, 8'h00);
    check("R7 R4 read mr2", rd, 8'h77);
    access(1'b0, 8'h00);
    check("R6 read stays mr2", rd, 8'h77);
    @(posedge clk); #1;
    check("R7 rd_valid one pulse", {7'd0, rv}, 8'h00);
  endtask

  task automatic t_rate;
    command(1'b1, 1'b0);
    access(1'b1, 8'hF7);
    check("R10 code 7 keeps rate", m0, 8'hF4);
    command(1'b1, 1'b0);
    access(1'b1, 8'h06);
    check("R10 code 6 keeps rate", m0, 8'h04);
    command(1'b1, 1'b0);
    access(1'b1, 8'h0D);
    check("R10 R8 code 5 stored", m0, 8'h05);
  endtask

  task automatic t_priority;
    command(1'b1, 1'b1);
    access(1'b1, 8'h99);
    check("R3 both cmds -> mr1", m1, 8'h99);
    check("R3 mr0 untouched", m0, 8'h05);
    command(1'b0, 1'b1);
    access(1'b1, 8'h5A);
    check("R3 cmd mr1 from mr2", m1, 8'h5A);
  endtask

  task automatic t_stall;
    @(negedge clk); cmd0 = 1'b1; av = 1'b1; aw = 1'b1; wd = 8'hEE; #1;
    check("R11 ready low", {7'd0, ardy}, 8'h00);
    @(posedge clk); #1; cmd0 = 1'b0; av = 1'b0; aw = 1'b0;
    check("R11 mr0 kept", m0, 8'h05); check("R11 mr1 kept", m1, 8'h5A);
    check("R11 mr2 kept", m2, 8'h77);
    access(1'b1, 8'h03);
    check("R11 pointer not stepped", m0, 8'h03);
    @(negedge clk); cmd1 = 1'b1; av = 1'b1; aw = 1'b0;
    @(posedge clk); #1; cmd1 = 1'b0; av = 1'b0;
    @(posedge clk); #1;
    check("R11 no read return", {7'd0, rv}, 8'h00);
  endtask

  task automatic t_chan_b;
    command(1'b1, 1'b0);
    access(1'b1, 8'hFF);
    check("R9 chan B low nibble zero", m0_b, 8'hF0);
    check("R8 chan A same write", m0, 8'hF7 & 8'hF3 | 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_steps();
    t_mr0();
    t_reads();
    t_rate();
    t_priority();
    t_stall();
    t_chan_b();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule